// File: doc/BRIEF.md
# Internal Address Space Router

This block sits beside an address translation unit and takes over the requests that carry the internal segment code. The upper bits of such a request's address name an internal space. The block resolves the access to one of three results: a routed physical address, a flag that the access targets an internal register, or a fault. Two spaces are served. The register window maps a few register numbers to non-overlapping slots. The port space covers ordinary ports and the two configuration ports, which reach device configuration space indirectly.

The block holds the 32-bit configuration address latch. A 4-byte write to the configuration address port loads it. An access to the data ports 0xCFC..0xCFF is then redirected into configuration space, but only while bit 31 of the latch is set. Each accepted request returns its result one cycle later.

A two-state machine sequences the result. In IDLE nothing is presented. An accepted request moves it to RESPOND, where the result is shown for one cycle. From RESPOND it stays in RESPOND if another accepted request arrives, and otherwise returns to IDLE.

Top module: `iar_top`

## Requirements
- R1: After reset, rsp_valid is 0 and the configuration latch is 0. A later data-port access therefore yields kind NOTARGET.
- R2: A request with req_valid=1 and req_seg=8 is accepted, and its result appears with rsp_valid=1 on the cycle after the clock edge that samples it. A request with any other req_seg gives no result and never loads the latch.
- R3: Address bits 63:60 select the space: 1 is the register window, 2 is the port space. Result kinds are ROUTED=0, INTREG=1, NOTARGET=2, GPF=3, BADSPACE=4. The register window recognises the numbers 0x10, 0x174, 0x175 and 0xC0000080 (in bits 59:0) as indices 0..3. For these it returns INTREG with rsp_paddr = index*8.
- R4: Any other register number in the register window gives GPF with rsp_paddr 0.
- R5: In the port space, port 0xCF8 with req_size=4 gives INTREG with rsp_paddr 32. If req_wr=1, the same request also loads req_wdata into the latch.
- R6: Ports 0xCFC..0xCFF with latch bit 31 set give ROUTED, with rsp_paddr = 0xC000_0000_0000_0000 OR latch bits 30:0.
- R7: Ports 0xCFC..0xCFF with latch bit 31 clear give NOTARGET with rsp_paddr 0.
- R8: Every other port, including 0xCF8 with a size other than 4, gives ROUTED with rsp_paddr = 0x8000_0000_0000_0000 OR the port number.
- R9: A port-space offset of 0x10000 or more gives GPF with rsp_paddr 0.
- R10: Any value of bits 63:60 other than 1 or 2 gives BADSPACE with rsp_paddr 0 and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_seg | input | 4 | Segment code of the request |
| req_vaddr | input | 64 | Internal address: space in 63:60, offset below |
| req_size | input | 4 | Access size in bytes |
| req_wr | input | 1 | Access is a write |
| req_wdata | input | 32 | Write data for the configuration latch |
| rsp_valid | output | 1 | Result present |
| rsp_kind | output | 3 | Result kind |
| rsp_paddr | output | 64 | Routed address or internal register slot |

## Verification
The assertions assume that req_seg, req_vaddr, req_size, req_wr and req_wdata are stable across each sampling edge. They also assume the latch changes only through an accepted write to port 0xCF8. The bench meets this by changing inputs only on falling edges. It draws random offsets from a narrow range around the configuration ports and the register numbers, so that the decision boundaries are hit often.

// File: rtl/iar_pkg.sv
package iar_pkg;
    typedef enum logic [2:0] {
        RSP_ROUTED   = 3'd0,
        RSP_INTREG   = 3'd1,
        RSP_NOTARGET = 3'd2,
        RSP_GPF      = 3'd3,
        RSP_BADSPACE = 3'd4
    } rsp_kind_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RESPOND = 1'b1
    } iar_state_e;
endpackage

// File: rtl/iar_reg_lookup.sv
module iar_reg_lookup #(
    parameter int OFF_W   = 60,
    parameter int NUM_REG = 4,
    parameter int IDX_W   = 3,
    parameter logic [NUM_REG*32-1:0] REG_IDS = {32'hC0000080, 32'h175, 32'h174, 32'h10}
) (
    input  logic [OFF_W-1:0] reg_num,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_REG-1:0] match;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_cmp
        assign match[g] = (reg_num == {{(OFF_W-32){1'b0}}, REG_IDS[g*32 +: 32]});
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_REG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/iar_port_router.sv
module iar_port_router
    import iar_pkg::*;
#(
    parameter int          ADDR_W    = 64,
    parameter int          OFF_W     = 60,
    parameter int          REG_SHIFT = 3,
    parameter int          CFG_IDX   = 4,
    parameter logic [63:0] IO_BASE   = 64'h8000_0000_0000_0000,
    parameter logic [63:0] PCI_BASE  = 64'hC000_0000_0000_0000
) (
    input  logic [OFF_W-1:0]  port_off,
    input  logic [3:0]        size,
    input  logic [31:0]       cfg_q,
    output rsp_kind_e         kind,
    output logic [ADDR_W-1:0] paddr,
    output logic              cfg_sel
);
    localparam logic [15:0] CFG_ADDR_PORT = 16'h0CF8;
    localparam logic [13:0] CFG_DATA_QUAD = 14'h0CFC >> 2;

    logic [15:0] port;
    logic        too_wide;

    assign port     = port_off[15:0];
    assign too_wide = |port_off[OFF_W-1:16];

    always_comb begin
        kind    = RSP_ROUTED;
        paddr   = '0;
        cfg_sel = 1'b0;
        if (too_wide) begin
            kind = RSP_GPF;
        end else if (port == CFG_ADDR_PORT && size == 4'd4) begin
            kind    = RSP_INTREG;
            paddr   = ADDR_W'(CFG_IDX) << REG_SHIFT;
            cfg_sel = 1'b1;
        end else if (port[15:2] == CFG_DATA_QUAD) begin
            if (cfg_q[31]) begin
                paddr = PCI_BASE[ADDR_W-1:0] | ADDR_W'(cfg_q[30:0]);
            end else begin
                kind = RSP_NOTARGET;
            end
        end else begin
            paddr = IO_BASE[ADDR_W-1:0] | ADDR_W'(port);
        end
    end
endmodule

// File: rtl/iar_top.sv
module iar_top
    import iar_pkg::*;
#(
    parameter int          ADDR_W    = 64,
    parameter int          PFX_W     = 4,
    parameter int          SEG_W     = 4,
    parameter logic [3:0]  INT_SEG   = 4'd8,
    parameter logic [3:0]  PFX_REG   = 4'd1,
    parameter logic [3:0]  PFX_PORT  = 4'd2,
    parameter int          NUM_REG   = 4,
    parameter logic [NUM_REG*32-1:0] REG_IDS = {32'hC0000080, 32'h175, 32'h174, 32'h10},
    parameter int          REG_BYTES = 8,
    parameter logic [63:0] IO_BASE   = 64'h8000_0000_0000_0000,
    parameter logic [63:0] PCI_BASE  = 64'hC000_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [3:0]        req_size,
    input  logic              req_wr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [ADDR_W-1:0] rsp_paddr
);
    localparam int OFF_W     = ADDR_W - PFX_W;
    localparam int IDX_W     = $clog2(NUM_REG + 1);
    localparam int REG_SHIFT = $clog2(REG_BYTES);

    iar_state_e        state_q, state_d;
    logic [31:0]       cfg_q;
    rsp_kind_e         kind_q, kind_d;
    logic [ADDR_W-1:0] paddr_q, paddr_d;

    logic [PFX_W-1:0]  pfx;
    logic [OFF_W-1:0]  off;
    logic              accept;
    logic              reg_hit;
    logic [IDX_W-1:0]  reg_idx;
    rsp_kind_e         port_kind;
    logic [ADDR_W-1:0] port_paddr;
    logic              port_cfg_sel;
    logic              cfg_load;

    assign pfx    = req_vaddr[ADDR_W-1:OFF_W];
    assign off    = req_vaddr[OFF_W-1:0];
    assign accept = req_valid && (req_seg == INT_SEG);

    iar_reg_lookup #(
        .OFF_W(OFF_W), .NUM_REG(NUM_REG), .IDX_W(IDX_W), .REG_IDS(REG_IDS)
    ) u_lookup (
        .reg_num(off), .hit(reg_hit), .idx(reg_idx)
    );

    iar_port_router #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .REG_SHIFT(REG_SHIFT), .CFG_IDX(NUM_REG),
        .IO_BASE(IO_BASE), .PCI_BASE(PCI_BASE)
    ) u_ports (
        .port_off(off), .size(req_size), .cfg_q(cfg_q),
        .kind(port_kind), .paddr(port_paddr), .cfg_sel(port_cfg_sel)
    );

    assign cfg_load = accept && (pfx == PFX_PORT) && port_cfg_sel && req_wr;

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = accept ? ST_RESPOND : ST_IDLE;
            ST_RESPOND: state_d = accept ? ST_RESPOND : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // result selection
    always_comb begin
        kind_d  = RSP_BADSPACE;
        paddr_d = '0;
        if (pfx == PFX_REG) begin
            if (reg_hit) begin
                kind_d  = RSP_INTREG;
                paddr_d = ADDR_W'(reg_idx) << REG_SHIFT;
            end else begin
                kind_d = RSP_GPF;
            end
        end else if (pfx == PFX_PORT) begin
            kind_d  = port_kind;
            paddr_d = port_paddr;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output and latch registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= RSP_ROUTED;
            paddr_q <= '0;
            cfg_q   <= '0;
        end else begin
            if (accept) begin
                kind_q  <= kind_d;
                paddr_q <= paddr_d;
            end
            if (cfg_load) begin
                cfg_q <= req_wdata;
            end
        end
    end

    assign rsp_valid = (state_q == ST_RESPOND);
    assign rsp_kind  = kind_q;
    assign rsp_paddr = paddr_q;

    // R2
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_seg == INT_SEG));

    // R4
    fault_paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind >= 3'd2) |-> (rsp_paddr == '0));

    // R7
    notarget_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd2) |-> !$past(cfg_q[31]));

    // R5
    latch_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> (rsp_valid && rsp_kind == 3'd1 && $past(req_wr)));

    // R3
    intreg_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd1) |-> (rsp_paddr[REG_SHIFT-1:0] == '0));
endmodule

// File: tb/iar_top_tb_top.sv
module iar_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [63:0] req_vaddr = '0;
    logic [3:0]  req_size = '0;
    logic        req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_kind;
    logic [63:0] rsp_paddr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_cfg = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    iar_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_vaddr(req_vaddr), .req_size(req_size), .req_wr(req_wr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_paddr(rsp_paddr)
    );

    function automatic void model(input logic [63:0] va, input logic [3:0] sz,
                                  output logic [2:0] k, output logic [63:0] p, output string tag);
        logic [59:0] off = va[59:0];
        k = 3'd4; p = '0; tag = "R10";
        if (va[63:60] == 4'd1) begin
            tag = "R4"; k = 3'd3;
            if (off == 60'h10)       begin k = 3'd1; p = 64'd0;  tag = "R3"; end
            if (off == 60'h174)      begin k = 3'd1; p = 64'd8;  tag = "R3"; end
            if (off == 60'h175)      begin k = 3'd1; p = 64'd16; tag = "R3"; end
            if (off == 60'hC0000080) begin k = 3'd1; p = 64'd24; tag = "R3"; end
        end else if (va[63:60] == 4'd2) begin
            if (off >= 60'h10000) begin k = 3'd3; tag = "R9"; end
            else if (off == 60'hCF8 && sz == 4'd4) begin k = 3'd1; p = 64'd32; tag = "R5"; end
            else if (off >= 60'hCFC && off <= 60'hCFF) begin
                if (m_cfg[31]) begin k = 3'd0; p = 64'hC000_0000_0000_0000 | {33'd0, m_cfg[30:0]}; tag = "R6"; end
                else begin k = 3'd2; tag = "R7"; end
            end else begin k = 3'd0; p = 64'h8000_0000_0000_0000 | {4'd0, off}; tag = "R8"; end
        end
    endfunction

    task automatic check(input string tag, input logic [2:0] ak, input logic [63:0] ap,
                         input logic [2:0] ek, input logic [63:0] ep);
        checks++;
        if (ak !== ek || ap !== ep) begin
            fails++;
            $display("FAIL %s kind/paddr actual %0d/%h expected %0d/%h", tag, ak, ap, ek, ep);
        end
    endtask

    task automatic issue(input logic [3:0] seg, input logic [63:0] va, input logic [3:0] sz,
                         input logic wr, input logic [31:0] wd);
        logic [2:0] ek; logic [63:0] ep; string tag;
        model(va, sz, ek, ep, tag);
        req_valid = 1'b1; req_seg = seg; req_vaddr = va; req_size = sz; req_wr = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (seg == 4'd8) begin
            checks++;
            if (rsp_valid !== 1'b1) begin fails++; $display("FAIL R2 rsp_valid actual %b expected 1", rsp_valid); end
            check(tag, rsp_kind, rsp_paddr, ek, ep);
            if (tag == "R5" && wr) m_cfg = wd;
        end else begin
            checks++;
            if (rsp_valid !== 1'b0) begin fails++; $display("FAIL R2 rsp_valid actual %b expected 0", rsp_valid); end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin fails++; $display("FAIL R1 rsp_valid actual %b expected 0", rsp_valid); end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin fails++; $display("FAIL R1 idle rsp_valid actual %b expected 0", rsp_valid); end
        // R1 latch cleared: data port has no target
        issue(4'd8, {4'd2, 60'hCFC}, 4'd4, 1'b0, 0);
        // R3 register window hits
        issue(4'd8, {4'd1, 60'h10}, 4'd8, 1'b0, 0);
        issue(4'd8, {4'd1, 60'hC0000080}, 4'd8, 1'b0, 0);
        // R4 miss
        issue(4'd8, {4'd1, 60'h176}, 4'd8, 1'b0, 0);
        // R2 other segment must not load the latch
        issue(4'd3, {4'd2, 60'hCF8}, 4'd4, 1'b1, 32'h8000_1234);
        issue(4'd8, {4'd2, 60'hCFF}, 4'd1, 1'b0, 0);
        // R5 load latch, R6 data ports
        issue(4'd8, {4'd2, 60'hCF8}, 4'd4, 1'b1, 32'h8001_2345);
        issue(4'd8, {4'd2, 60'hCFC}, 4'd4, 1'b0, 0);
        issue(4'd8, {4'd2, 60'hCFF}, 4'd1, 1'b0, 0);
        // R8 neighbours and short access to CF8
        issue(4'd8, {4'd2, 60'hCF8}, 4'd2, 1'b1, 32'h0);
        issue(4'd8, {4'd2, 60'hCFB}, 4'd1, 1'b0, 0);
        issue(4'd8, {4'd2, 60'hD00}, 4'd1, 1'b0, 0);
        // R9 boundary
        issue(4'd8, {4'd2, 60'hFFFF}, 4'd1, 1'b0, 0);
        issue(4'd8, {4'd2, 60'h10000}, 4'd1, 1'b0, 0);
        // R10 unknown space, then latch unchanged
        issue(4'd8, {4'd0, 60'hCF8}, 4'd4, 1'b1, 32'h0);
        issue(4'd8, {4'd2, 60'hCFD}, 4'd2, 1'b0, 0);
        // R7 clear enable bit
        issue(4'd8, {4'd2, 60'hCF8}, 4'd4, 1'b1, 32'h0000_0F00);
        issue(4'd8, {4'd2, 60'hCFE}, 4'd2, 1'b0, 0);
        for (int i = 0; i < 400; i++) begin
            logic [3:0] sp; logic [59:0] off; logic [3:0] seg;
            int pick = $urandom_range(0, 9);
            sp  = (pick < 4) ? 4'd2 : (pick < 8) ? 4'd1 : 4'($urandom_range(0, 15));
            seg = ($urandom_range(0, 7) == 0) ? 4'd5 : 4'd8;
            case ($urandom_range(0, 3))
                0: off = 60'($urandom_range(32'hCF6, 32'hD01));
                1: off = 60'($urandom_range(32'h173, 32'h176));
                2: off = ($urandom_range(0, 1) == 1) ? 60'hC0000080 : 60'h10;
                default: off = 60'($urandom_range(0, 32'h1FFFF));
            endcase
            issue(seg, {sp, off}, 4'($urandom_range(1, 8)), 1'($urandom_range(0, 1)), $urandom);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule